// File: doc/BRIEF.md
# Time-Sliced Video Memory Arbiter

This block lets a CPU and a video readout engine share one single-port synchronous memory. Memory cycles alternate in a fixed pattern: even cycles belong to the video side and odd cycles belong to the CPU side. The slot counter wraps once per pixel group of `GROUP_CYCLES` clocks, an even whole-number multiple of the pixel rate. The video fetch always takes the first slot of the group (phase 0). For the 800x600, 60 Hz mode the pixel clock is 40 MHz, so with the default of four clocks per group the block runs at 160 MHz.

CPU writes go into a single posted buffer and are acknowledged at once. The buffered write is committed in the next CPU slot. CPU reads wait for a CPU slot in which the buffer is empty. A read therefore never overtakes an older write, and buffered data is not forwarded even when the addresses match. Fetched video words are registered and held until the next fetch, so CPU traffic never disturbs the word sent toward the display.

Top module: `vmem_slot_arbiter`

## Requirements
- R1: After reset is released, the phase counts 0,1,…,GROUP_CYCLES-1 and wraps. The first cycle after reset is phase 0. Even phases are video slots and odd phases are CPU slots. A memory write (`mem_en`=1, `mem_we`=1) occurs only in a CPU slot.
- R2: In phase 0, if `vid_req` is high, the block issues a memory read of `vid_addr`. The returned word appears on `vid_data` in phase 2 of the same group, with `vid_strobe` high for that one cycle only.
- R3: `vid_data` changes only in a cycle where `vid_strobe` is high. It keeps its value through all CPU activity.
- R4: A CPU write (`cpu_req`=1, `cpu_we`=1) made while the buffer is empty gets `cpu_ready`=1 in the same cycle, and the write is captured into the buffer.
- R5: A buffered write is committed in the first CPU slot after it was captured: `mem_en`=1, `mem_we`=1, with the buffered address and data. The buffer is empty after that cycle.
- R6: A CPU write made while the buffer is full gets `cpu_ready`=0 until the buffer has been committed.
- R7: A CPU read is issued to memory only in a CPU slot with an empty buffer. In the next cycle `cpu_ready`=1 and `cpu_rdata` carries the memory word.
- R8: A CPU read waits for the commit of a pending buffered write, even to the same address, and then returns the newly written data.
- R9: During reset `mem_en`, `cpu_ready` and `vid_strobe` are 0 and `vid_data` is 0.
- R10: A slot whose requester has nothing to do leaves `mem_en` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | CPU access request, held until ready |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | CPU word address |
| cpu_wdata | input | DATA_W | CPU write data |
| cpu_ready | output | 1 | Write accepted / read data valid |
| cpu_rdata | output | DATA_W | CPU read data, valid with ready on a read |
| vid_req | input | 1 | Video fetch request, sampled in phase 0 |
| vid_addr | input | ADDR_W | Video fetch address |
| vid_data | output | DATA_W | Held fetched video word |
| vid_strobe | output | 1 | One-cycle pulse when vid_data updates |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, one cycle after a read |

## Verification
The bench targets several slot and buffer timing cases. It issues back-to-back writes, where a design that accepts the second write early would silently drop the first. It issues a read right behind a write to the same address, where a design that lets the read overtake the write returns stale data. It puts a CPU read in the slot after a video fetch, where a misrouted capture would place CPU data on the display word or let the video word change between strobes. Writes captured in either slot kind check the retire slot, since a wrong retire would show up as a memory write during a video slot.

// File: rtl/vmem_arb_pkg.sv
package vmem_arb_pkg;

    typedef enum logic {
        SLOT_VIDEO = 1'b0,
        SLOT_CPU   = 1'b1
    } slot_e;

    typedef enum logic [1:0] {
        SRC_NONE   = 2'd0,
        SRC_VIDEO  = 2'd1,
        SRC_CPU_RD = 2'd2,
        SRC_CPU_WR = 2'd3
    } mem_src_e;

    function automatic slot_e slot_of_phase(input logic phase_lsb);
        return phase_lsb ? SLOT_CPU : SLOT_VIDEO;
    endfunction

endpackage

// File: rtl/slot_sequencer.sv
module slot_sequencer
    import vmem_arb_pkg::*;
#(
    parameter int GROUP_CYCLES = 4,
    localparam int PH_W = (GROUP_CYCLES > 2) ? $clog2(GROUP_CYCLES) : 1
) (
    input  logic            clk,
    input  logic            rst,
    output logic [PH_W-1:0] phase,
    output slot_e           slot,
    output logic            fetch_phase
);

    localparam logic [PH_W-1:0] PH_LAST = PH_W'(GROUP_CYCLES - 1);

    logic [PH_W-1:0] phase_q;

    always_ff @(posedge clk) begin
        if (rst)
            phase_q <= '0;
        else if (phase_q == PH_LAST)
            phase_q <= '0;
        else
            phase_q <= phase_q + 1'b1;
    end

    assign phase       = phase_q;
    assign slot        = slot_of_phase(phase_q[0]);
    assign fetch_phase = (phase_q == '0);

    AST_SLOT_ALTERNATE: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (slot != $past(slot)))
        else $error("slot did not alternate"); // R1

endmodule

// File: rtl/cpu_port.sv
module cpu_port
    import vmem_arb_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  slot_e             slot,
    output logic              cpu_ready,
    output logic              buf_valid,
    output logic              wr_issue,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              rd_issue
);

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } wbuf_t;

    wbuf_t wbuf_q;
    logic  rd_pend_q;
    logic  wr_accept;
    logic  in_cpu_slot;

    assign in_cpu_slot = (slot == SLOT_CPU);
    assign wr_accept   = cpu_req && cpu_we && !wbuf_q.valid && !rd_pend_q;
    assign wr_issue    = in_cpu_slot && wbuf_q.valid;
    assign rd_issue    = in_cpu_slot && !wbuf_q.valid && !rd_pend_q
                         && cpu_req && !cpu_we;
    assign cpu_ready   = wr_accept || rd_pend_q;
    assign buf_valid   = wbuf_q.valid;
    assign wr_addr     = wbuf_q.addr;
    assign wr_data     = wbuf_q.data;

    always_ff @(posedge clk) begin
        if (rst) begin
            wbuf_q    <= '0;
            rd_pend_q <= 1'b0;
        end else begin
            rd_pend_q <= rd_issue;
            if (wr_accept) begin
                wbuf_q.valid <= 1'b1;
                wbuf_q.addr  <= cpu_addr;
                wbuf_q.data  <= cpu_wdata;
            end else if (wr_issue) begin
                wbuf_q.valid <= 1'b0;
            end
        end
    end

    AST_WR_ACCEPT_FILLS: assert property (@(posedge clk) disable iff (rst)
        (cpu_ready && cpu_req && cpu_we) |=> buf_valid)
        else $error("accepted write not buffered"); // R4

    AST_FULL_STALLS: assert property (@(posedge clk) disable iff (rst)
        (buf_valid && cpu_req && cpu_we) |-> !cpu_ready)
        else $error("write acknowledged while buffer full"); // R6

    AST_RETIRE_IN_SLOT: assert property (@(posedge clk) disable iff (rst)
        (buf_valid && slot == SLOT_CPU) |=> !buf_valid)
        else $error("buffered write not retired"); // R5

    AST_RD_BEHIND_WR: assert property (@(posedge clk) disable iff (rst)
        rd_issue |-> (!buf_valid && slot == SLOT_CPU))
        else $error("read overtook buffered write"); // R8

    AST_RD_READY_NEXT: assert property (@(posedge clk) disable iff (rst)
        rd_issue |=> cpu_ready)
        else $error("read data not acknowledged"); // R7

endmodule

// File: rtl/video_fetch.sv
module video_fetch
    import vmem_arb_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fetch_phase,
    input  logic              vid_req,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              fetch_issue,
    output logic [DATA_W-1:0] vid_data,
    output logic              vid_strobe
);

    logic              pend_q;
    logic [DATA_W-1:0] data_q;
    logic              strobe_q;

    assign fetch_issue = fetch_phase && vid_req;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q   <= 1'b0;
            data_q   <= '0;
            strobe_q <= 1'b0;
        end else begin
            pend_q   <= fetch_issue;
            strobe_q <= pend_q;
            if (pend_q)
                data_q <= mem_rdata;
        end
    end

    assign vid_data   = data_q;
    assign vid_strobe = strobe_q;

    AST_FETCH_AT_PHASE0: assert property (@(posedge clk) disable iff (rst)
        fetch_issue |-> fetch_phase)
        else $error("video fetch off its phase"); // R2

    AST_STROBE_AFTER_FETCH: assert property (@(posedge clk) disable iff (rst)
        vid_strobe |-> $past(fetch_issue, 2))
        else $error("strobe without fetch"); // R2

    AST_VID_HOLD: assert property (@(posedge clk) disable iff (rst)
        !vid_strobe |-> $stable(vid_data))
        else $error("video word changed between strobes"); // R3

endmodule

// File: rtl/vmem_slot_arbiter.sv
module vmem_slot_arbiter
    import vmem_arb_pkg::*;
#(
    parameter int ADDR_W       = 16,
    parameter int DATA_W       = 16,
    parameter int GROUP_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_ready,
    output logic [DATA_W-1:0] cpu_rdata,
    input  logic              vid_req,
    input  logic [ADDR_W-1:0] vid_addr,
    output logic [DATA_W-1:0] vid_data,
    output logic              vid_strobe,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata
);

    localparam int PH_W = (GROUP_CYCLES > 2) ? $clog2(GROUP_CYCLES) : 1;

    logic [PH_W-1:0]   phase;
    slot_e             slot;
    logic              fetch_phase;
    logic              buf_valid;
    logic              wr_issue;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;
    logic              rd_issue;
    logic              fetch_issue;
    mem_src_e          src;

    slot_sequencer #(.GROUP_CYCLES(GROUP_CYCLES)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .phase       (phase),
        .slot        (slot),
        .fetch_phase (fetch_phase)
    );

    cpu_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cpu (
        .clk       (clk),
        .rst       (rst),
        .cpu_req   (cpu_req),
        .cpu_we    (cpu_we),
        .cpu_addr  (cpu_addr),
        .cpu_wdata (cpu_wdata),
        .slot      (slot),
        .cpu_ready (cpu_ready),
        .buf_valid (buf_valid),
        .wr_issue  (wr_issue),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_issue  (rd_issue)
    );

    video_fetch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_vid (
        .clk         (clk),
        .rst         (rst),
        .fetch_phase (fetch_phase),
        .vid_req     (vid_req),
        .mem_rdata   (mem_rdata),
        .fetch_issue (fetch_issue),
        .vid_data    (vid_data),
        .vid_strobe  (vid_strobe)
    );

    always_comb begin
        if (slot == SLOT_VIDEO)
            src = fetch_issue ? SRC_VIDEO : SRC_NONE;
        else if (wr_issue)
            src = SRC_CPU_WR;
        else if (rd_issue)
            src = SRC_CPU_RD;
        else
            src = SRC_NONE;
    end

    always_comb begin
        mem_en    = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        unique case (src)
            SRC_VIDEO: begin
                mem_en   = 1'b1;
                mem_addr = vid_addr;
            end
            SRC_CPU_RD: begin
                mem_en   = 1'b1;
                mem_addr = cpu_addr;
            end
            SRC_CPU_WR: begin
                mem_en    = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = wr_addr;
                mem_wdata = wr_data;
            end
            default: ;
        endcase
    end

    assign cpu_rdata = mem_rdata;

    AST_NO_VIDEO_SLOT_WRITE: assert property (@(posedge clk) disable iff (rst)
        (mem_en && mem_we) |-> (phase[0] == 1'b1))
        else $error("write in video slot"); // R1

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!cpu_req && !buf_valid && !fetch_issue) |-> !mem_en)
        else $error("memory enabled with no requester"); // R10

endmodule

// File: tb/vmem_slot_arbiter_tb.sv
module vmem_slot_arbiter_tb;

    localparam int AW = 8;
    localparam int DW = 16;
    localparam int GC = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cpu_req = 1'b0, cpu_we = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic [DW-1:0] cpu_wdata = '0;
    logic          cpu_ready;
    logic [DW-1:0] cpu_rdata;
    logic          vid_req = 1'b0;
    logic [AW-1:0] vid_addr = '0;
    logic [DW-1:0] vid_data;
    logic          vid_strobe;
    logic          mem_en, mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata = '0;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    vmem_slot_arbiter #(.ADDR_W(AW), .DATA_W(DW), .GROUP_CYCLES(GC)) u_dut (
        .clk(clk), .rst(rst),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
        .vid_req(vid_req), .vid_addr(vid_addr), .vid_data(vid_data),
        .vid_strobe(vid_strobe),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // Memory array attached to the memory port
    logic [DW-1:0] ram [0:(1<<AW)-1];
    initial for (int i = 0; i < (1 << AW); i++) ram[i] = DW'(i * 37 + 5);
    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) ram[mem_addr] <= mem_wdata;
            else        mem_rdata <= ram[mem_addr];
        end
    end

    // Behavioural reference state
    int unsigned   m_cyc;
    bit            m_bufv, m_rdpend, m_vpend, m_vstrobe;
    logic [AW-1:0] m_bufa;
    logic [DW-1:0] m_bufd, m_rdval, m_vval, m_vdata;
    logic [DW-1:0] shadow [0:(1<<AW)-1];
    initial for (int i = 0; i < (1 << AW); i++) shadow[i] = DW'(i * 37 + 5);

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h cycle=%0d",
                     tag, what, act, exp, cycles);
        end
    endtask

    always @(negedge clk) begin
        cycles++;
        if (rst) begin
            m_cyc = 0; m_bufv = 0; m_rdpend = 0; m_vpend = 0;
            m_vstrobe = 0; m_vdata = '0;
            chk("R9", "mem_en", 32'(mem_en), 0);
            chk("R9", "cpu_ready", 32'(cpu_ready), 0);
            chk("R9", "vid_strobe", 32'(vid_strobe), 0);
            chk("R9", "vid_data", 32'(vid_data), 0);
        end else begin
            int  ph;
            bit  cslot, e_wr, e_rdc, e_vid, e_acc, e_en, e_we;
            logic [AW-1:0] e_addr;
            logic [DW-1:0] e_wdata;
            string tag;
            ph     = int'(m_cyc % GC);
            cslot  = (ph % 2) == 1;
            e_wr   = cslot && m_bufv;
            e_rdc  = cslot && !m_bufv && !m_rdpend && cpu_req && !cpu_we;
            e_vid  = (ph == 0) && vid_req;
            e_acc  = cpu_req && cpu_we && !m_bufv && !m_rdpend;
            e_en   = e_wr || e_rdc || e_vid;
            e_we   = e_wr;
            e_addr = e_wr ? m_bufa : e_rdc ? cpu_addr : e_vid ? vid_addr : '0;
            e_wdata = e_wr ? m_bufd : '0;
            tag = e_wr ? "R5" : e_rdc ? "R7" : e_vid ? "R2" :
                  (cpu_req && !cpu_we && m_bufv) ? "R8" : "R10";
            chk(tag, "mem_en", 32'(mem_en), 32'(e_en));
            chk((mem_we && !cslot) ? "R1" : tag, "mem_we", 32'(mem_we), 32'(e_we));
            if (e_en) chk(tag, "mem_addr", 32'(mem_addr), 32'(e_addr));
            if (e_wr) chk("R5", "mem_wdata", 32'(mem_wdata), 32'(e_wdata));
            tag = m_rdpend ? "R7" :
                  (cpu_req && cpu_we && m_bufv) ? "R6" :
                  (cpu_req && !cpu_we) ? "R8" : "R4";
            chk(tag, "cpu_ready", 32'(cpu_ready), 32'(m_rdpend || e_acc));
            if (m_rdpend) chk("R8", "cpu_rdata", 32'(cpu_rdata), 32'(m_rdval));
            chk("R2", "vid_strobe", 32'(vid_strobe), 32'(m_vstrobe));
            chk("R3", "vid_data", 32'(vid_data), 32'(m_vdata));
            // advance to the next edge
            m_vstrobe = m_vpend;
            if (m_vpend) m_vdata = m_vval;
            m_vpend = e_vid;
            if (e_vid) m_vval = shadow[vid_addr];
            m_rdpend = e_rdc;
            if (e_rdc) m_rdval = shadow[cpu_addr];
            if (e_wr) begin shadow[m_bufa] = m_bufd; m_bufv = 0; end
            if (e_acc) begin m_bufv = 1; m_bufa = cpu_addr; m_bufd = cpu_wdata; end
            m_cyc++;
        end
    end

    task automatic cpu_op(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(posedge clk); #1;
        cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
        forever begin
            @(negedge clk);
            if (cpu_ready) break;
        end
        @(posedge clk); #1;
        cpu_req = 0;
    endtask

    // Video requester: fetches on most groups, addresses rising
    always @(posedge clk) begin
        #1;
        if (!rst) begin
            vid_req  = (cycles % 28) < 20;
            vid_addr = AW'(cycles / 4 + 8'h40);
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 0;
        repeat (9) @(posedge clk);
        cpu_op(1, 8'h10, 16'hAAAA);           // R4 R5 single write
        cpu_op(1, 8'h11, 16'hBBBB);           // R6 back-to-back
        cpu_op(1, 8'h12, 16'hCCCC);
        cpu_op(0, 8'h12, 16'h0);              // R8 read behind same address
        cpu_op(0, 8'h20, 16'h0);              // R7 plain read
        cpu_op(0, 8'h41, 16'h0);              // read near video addresses
        repeat (7) @(posedge clk);            // R10 idle slots
        for (int i = 0; i < 300; i++) begin
            logic [AW-1:0] a;
            a = AW'((i * 13) % 24);
            cpu_op((i % 3) != 2, a, DW'(i * 257 + 3));
            if (i % 5 == 0) repeat (i % 4) @(posedge clk);
        end
        repeat (10) @(posedge clk);
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog expired");
            end
        join_any
        @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule